// File: doc/BRIEF.md
# Byte-wide asynchronous SRAM access controller

This block sits on a processor's register bus and lets software move words between the processor and an external asynchronous SRAM that has only an 8-bit data bus and a 22-bit address bus. Software programs a base address and two offset registers, and picks a word length of 8, 16 or 24 bits. The block then breaks each word into one, two or three byte accesses at consecutive addresses, least significant byte first. After each word, the offset that was used advances by the word's byte count, so that a stream of words fills or empties a buffer with no further address writes.

A write starts when software stores a word in the write-data register. A read starts in one of two ways, chosen by a configuration bit. It can start when an offset register is written, and then uses the new offset. It can also start when the read-data register is read; that read returns the previously assembled word and fetches the next one. Each strobe stays low for one of four programmable widths. The address is set up one clock before the strobe falls and is held one clock after it rises. Completion shows up in a sticky done flag, which can be polled or routed to an interrupt. A request made while an access is still running is dropped, and this is recorded in a sticky overrun flag.

Top module: `bytewide_sram_ctrl`

## Requirements
- R1: After reset, busy, done and overrun (control register bits 8, 9, 10) read 0, both strobes are high, the data bus is not driven and irq is low.
- R2: Writing the write-data register (register 4) while idle writes the word's bytes least significant first, at consecutive addresses. The first address is base (register 1) plus the offset selected by control bit 5 (0 picks register 2, 1 picks register 3), computed modulo 2^22.
- R3: Control bits [1:0] set the word length: 0 gives one byte, 1 gives two bytes, and 2 or 3 give three bytes. The read-data register (register 5) returns the assembled read word with its unused upper bytes as zero.
- R4: Control bits [3:2] set the strobe-low width: 0, 1, 2 and 3 give 2, 3, 4 and 6 clocks. The address is valid one clock before the strobe falls and is held for one clock after it rises.
- R5: With control bit 4 clear, writing offset register 2 or 3 loads it and starts a read at base plus the new value. Reading register 5 starts nothing.
- R6: With control bit 4 set, reading register 5 returns the last assembled word and starts a read at base plus the offset chosen by control bit 5. Writing an offset register only loads it.
- R7: When an access completes, the offset it used grows by the word's byte count, modulo 2^22. Offset registers read back their current value.
- R8: Busy (bit 8) reads 1 while an access runs. Done (bit 9) is set when the access completes, cleared when the next one starts, and cleared by writing 1 to bit 9 of the control register.
- R9: irq equals done AND the interrupt-enable bit (control bit 6).
- R10: A start request made while busy (a data write, an offset write in mode 0, or a data read in mode 1) produces no access and sets the sticky overrun flag (bit 10), which is cleared by writing 1 to bit 10. An offset write made while busy leaves the offset unchanged.
- R11: At most one strobe is low at any time. The data bus is driven during write accesses only, and never while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe, one cycle |
| reg_rd | input | 1 | Register read strobe, one cycle |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data, valid in the same cycle as reg_addr |
| irq | output | 1 | Completion interrupt, level |
| sram_addr | output | 22 | External byte address |
| sram_dq_o | output | 8 | External data out |
| sram_dq_i | input | 8 | External data in |
| sram_dq_oe | output | 1 | Data bus output enable |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Read strobe, active low |

## Verification
The bench builds the block with its default parameters: a 22-bit address, a byte bus, and strobe widths of 2, 3, 4 and 6 clocks. With these values, every timing code and every word length can be run in turn. The full address width lets a word straddle the top of the address space, so both the byte-address wrap and the offset wrap are reached. The six-clock setting leaves a window long enough to inject overrun requests, and offset writes, in the middle of an access.

// File: rtl/sram_bb_pkg.sv
package sram_bb_pkg;

  typedef enum logic [2:0] {
    RA_CTRL  = 3'd0,
    RA_BASE  = 3'd1,
    RA_OFS0  = 3'd2,
    RA_OFS1  = 3'd3,
    RA_WDATA = 3'd4,
    RA_RDATA = 3'd5
  } reg_sel_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_STRB, SQ_HOLD} seq_state_e;

  localparam int CB_BUSY = 8;
  localparam int CB_DONE = 9;
  localparam int CB_OVR  = 10;

  // Packed so that ie lands on bit 6 and len on bits 1:0.
  typedef struct packed {
    logic       ie;
    logic       osel;
    logic       fetch;
    logic [1:0] tsel;
    logic [1:0] len;
  } cfg_t;

  function automatic logic [1:0] word_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 2'd1;
      2'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

endpackage

// File: rtl/sram_bb_regs.sv
module sram_bb_regs
  import sram_bb_pkg::*;
#(
  parameter int AW = 22,
  parameter int WW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] wd,
  input  logic          busy,
  input  logic          fin,
  input  logic [WW-1:0] rd_word,
  output logic [WW-1:0] reg_rdata,
  output cfg_t          cfg,
  output logic          start,
  output logic          start_wr,
  output logic [AW-1:0] start_addr,
  output logic          req_busy,
  output logic          done_q,
  output logic          ovr_q,
  output logic          irq
);

  logic [AW-1:0] base_q;
  logic [AW-1:0] ofs_q [2];
  logic          act_sel;
  logic [1:0]    act_nb;

  logic wr_ctrl, wr_ofs, ofs_idx, req_wr, req_ofs, req_fetch, req_any, sel_now;
  logic [AW-1:0] ofs_now;

  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign wr_ofs    = reg_wr && ((reg_addr == RA_OFS0) || (reg_addr == RA_OFS1));
  assign ofs_idx   = (reg_addr == RA_OFS1);
  assign req_wr    = reg_wr && (reg_addr == RA_WDATA);
  assign req_ofs   = wr_ofs && !cfg.fetch;
  assign req_fetch = reg_rd && (reg_addr == RA_RDATA) && cfg.fetch;
  assign req_any   = req_wr || req_ofs || req_fetch;

  assign start     = req_any && !busy;
  assign req_busy  = req_any && busy;
  assign start_wr  = req_wr;

  // An offset-triggered read uses the value being written.
  assign sel_now    = req_ofs ? ofs_idx : cfg.osel;
  assign ofs_now    = req_ofs ? wd : ofs_q[sel_now];
  assign start_addr = base_q + ofs_now;

  assign irq = done_q && cfg.ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      base_q   <= '0;
      ofs_q[0] <= '0;
      ofs_q[1] <= '0;
      act_sel  <= 1'b0;
      act_nb   <= 2'd1;
      done_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      if (wr_ctrl) cfg <= cfg_t'(wd[6:0]);
      if (reg_wr && (reg_addr == RA_BASE)) base_q <= wd;
      if (wr_ofs && !busy) ofs_q[ofs_idx] <= wd;
      if (start) begin
        act_sel <= sel_now;
        act_nb  <= word_bytes(cfg.len);
      end
      if (fin) ofs_q[act_sel] <= ofs_q[act_sel] + AW'(act_nb);

      if (wr_ctrl && wd[CB_DONE]) done_q <= 1'b0;
      if (start)                  done_q <= 1'b0;
      if (fin)                    done_q <= 1'b1;

      if (wr_ctrl && wd[CB_OVR])  ovr_q <= 1'b0;
      if (req_busy)               ovr_q <= 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTRL:  reg_rdata = WW'({ovr_q, done_q, busy, 1'b0, cfg});
      RA_BASE:  reg_rdata = WW'(base_q);
      RA_OFS0:  reg_rdata = WW'(ofs_q[0]);
      RA_OFS1:  reg_rdata = WW'(ofs_q[1]);
      RA_RDATA: reg_rdata = rd_word;
      default:  reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/sram_bb_seq.sv
module sram_bb_seq
  import sram_bb_pkg::*;
#(
  parameter int AW      = 22,
  parameter int BW      = 8,
  parameter int NB      = 3,
  parameter int CW      = 3,
  parameter int STRB_W0 = 2,
  parameter int STRB_W1 = 3,
  parameter int STRB_W2 = 4,
  parameter int STRB_W3 = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_wr,
  input  logic [AW-1:0]    start_addr,
  input  logic [1:0]       len,
  input  logic [1:0]       tsel,
  input  logic [NB*BW-1:0] wdata,
  input  logic [BW-1:0]    sram_dq_i,
  output logic             busy,
  output logic             fin,
  output logic [NB*BW-1:0] rd_word,
  output logic [CW-1:0]    width_q,
  output logic [AW-1:0]    sram_addr,
  output logic [BW-1:0]    sram_dq_o,
  output logic             sram_dq_oe,
  output logic             sram_we_n,
  output logic             sram_oe_n
);

  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  seq_state_e       st;
  logic             is_wr;
  logic [1:0]       nb_q;
  logic [IW-1:0]    bidx;
  logic [CW-1:0]    cnt;
  logic [NB*BW-1:0] wbuf;
  logic             last_byte;

  function automatic logic [CW-1:0] strobe_width(input logic [1:0] t);
    case (t)
      2'd0:    return CW'(STRB_W0);
      2'd1:    return CW'(STRB_W1);
      2'd2:    return CW'(STRB_W2);
      default: return CW'(STRB_W3);
    endcase
  endfunction

  assign last_byte  = (2'(bidx) == nb_q - 2'd1);
  assign busy       = (st != SQ_IDLE);
  assign fin        = (st == SQ_HOLD) && last_byte;
  assign sram_we_n  = !((st == SQ_STRB) && is_wr);
  assign sram_oe_n  = !((st == SQ_STRB) && !is_wr);
  assign sram_dq_oe = busy && is_wr;
  assign sram_dq_o  = wbuf[bidx*BW +: BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      is_wr     <= 1'b0;
      nb_q      <= 2'd1;
      bidx      <= '0;
      cnt       <= '0;
      width_q   <= CW'(STRB_W0);
      sram_addr <= '0;
      wbuf      <= '0;
      rd_word   <= '0;
    end else begin
      case (st)
        SQ_IDLE: if (start) begin
          st        <= SQ_SETUP;
          is_wr     <= start_wr;
          nb_q      <= word_bytes(len);
          bidx      <= '0;
          width_q   <= strobe_width(tsel);
          sram_addr <= start_addr;
          if (start_wr) wbuf    <= wdata;
          else          rd_word <= '0;
        end
        SQ_SETUP: begin
          st  <= SQ_STRB;
          cnt <= CW'(1);
        end
        SQ_STRB: begin
          if (cnt == width_q) begin
            st <= SQ_HOLD;
            if (!is_wr) rd_word[bidx*BW +: BW] <= sram_dq_i;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          if (last_byte) begin
            st <= SQ_IDLE;
          end else begin
            st        <= SQ_SETUP;
            bidx      <= bidx + IW'(1);
            sram_addr <= sram_addr + AW'(1);
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/bytewide_sram_ctrl.sv
module bytewide_sram_ctrl
  import sram_bb_pkg::*;
#(
  parameter int AW      = 22,
  parameter int BW      = 8,
  parameter int STRB_W0 = 2,
  parameter int STRB_W1 = 3,
  parameter int STRB_W2 = 4,
  parameter int STRB_W3 = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     reg_addr,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [3*BW-1:0] reg_wdata,
  output logic [3*BW-1:0] reg_rdata,
  output logic           irq,
  output logic [AW-1:0]  sram_addr,
  output logic [BW-1:0]  sram_dq_o,
  input  logic [BW-1:0]  sram_dq_i,
  output logic           sram_dq_oe,
  output logic           sram_we_n,
  output logic           sram_oe_n
);

  localparam int NB    = 3;
  localparam int WW    = NB * BW;
  localparam int WMAXA = (STRB_W0 > STRB_W1) ? STRB_W0 : STRB_W1;
  localparam int WMAXB = (STRB_W2 > STRB_W3) ? STRB_W2 : STRB_W3;
  localparam int WMAX  = (WMAXA > WMAXB) ? WMAXA : WMAXB;
  localparam int CW    = $clog2(WMAX + 1);

  // Named internal events, observed by the bound checker.
  cfg_t          cfg;
  logic          busy, acc_fin, acc_start, start_wr, req_busy, done_flag, ovr_flag;
  logic [AW-1:0] start_addr;
  logic [WW-1:0] rd_word;
  logic [CW-1:0] act_width;

  sram_bb_regs #(.AW(AW), .WW(WW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .wd(reg_wdata[AW-1:0]),
    .busy(busy), .fin(acc_fin), .rd_word(rd_word),
    .reg_rdata(reg_rdata), .cfg(cfg),
    .start(acc_start), .start_wr(start_wr), .start_addr(start_addr),
    .req_busy(req_busy), .done_q(done_flag), .ovr_q(ovr_flag), .irq(irq)
  );

  sram_bb_seq #(
    .AW(AW), .BW(BW), .NB(NB), .CW(CW),
    .STRB_W0(STRB_W0), .STRB_W1(STRB_W1), .STRB_W2(STRB_W2), .STRB_W3(STRB_W3)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(acc_start), .start_wr(start_wr), .start_addr(start_addr),
    .len(cfg.len), .tsel(cfg.tsel), .wdata(reg_wdata),
    .sram_dq_i(sram_dq_i),
    .busy(busy), .fin(acc_fin), .rd_word(rd_word), .width_q(act_width),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
    .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

endmodule

// File: rtl/sram_bb_chk.sv
module sram_bb_chk #(
  parameter int AW = 22,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sram_we_n,
  input logic          sram_oe_n,
  input logic          sram_dq_oe,
  input logic [AW-1:0] sram_addr,
  input logic          busy,
  input logic          acc_fin,
  input logic          acc_start,
  input logic          req_busy,
  input logic          done_flag,
  input logic          ovr_flag,
  input logic [CW-1:0] act_width
);

  logic       strobe_low;
  logic [7:0] low_run;

  assign strobe_low = !sram_we_n || !sram_oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          low_run <= '0;
    else if (strobe_low) low_run <= low_run + 8'd1;
    else                 low_run <= '0;
  end

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  a_r11_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_low |=> $stable(sram_addr));

  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_low && low_run != 8'd0) |-> (low_run == 8'(act_width)));

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sram_we_n && sram_oe_n && !sram_dq_oe));

  a_r8_done_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fin |=> (done_flag && !busy));

  a_r8_start_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (!done_flag && busy));

  a_r10_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    req_busy |=> ovr_flag);

endmodule

bind bytewide_sram_ctrl sram_bb_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe),
  .sram_addr(sram_addr), .busy(busy), .acc_fin(acc_fin), .acc_start(acc_start),
  .req_busy(req_busy), .done_flag(done_flag), .ovr_flag(ovr_flag),
  .act_width(act_width)
);

// File: tb/sim_bytewide_sram_ctrl.sv
module sim_bytewide_sram_ctrl;

  localparam logic [2:0] A_CTRL = 3'd0, A_BASE = 3'd1, A_OFS0 = 3'd2,
                         A_OFS1 = 3'd3, A_WDAT = 3'd4, A_RDAT = 3'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [23:0] reg_wdata = '0;
  logic [23:0] reg_rdata;
  logic        irq;
  logic [21:0] sram_addr;
  logic [7:0]  sram_dq_o, sram_dq_i;
  logic        sram_dq_oe, sram_we_n, sram_oe_n;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = !clk;

  bytewide_sram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .sram_addr(sram_addr), .sram_dq_o(sram_dq_o), .sram_dq_i(sram_dq_i),
    .sram_dq_oe(sram_dq_oe), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  // External memory model, indexed by the low 12 address bits.
  logic [7:0] mem [4096];
  assign sram_dq_i = mem[sram_addr[11:0]];

  typedef struct {
    bit          wr;
    logic [21:0] a;
    logic [7:0]  d;
    int          w;
    string       tag;
  } acc_t;
  acc_t exp_q[$];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic int width_of(int tsel);
    case (tsel)
      0: return 2;
      1: return 3;
      2: return 4;
      default: return 6;
    endcase
  endfunction

  // Driver side of the scoreboard: one item per expected byte access.
  task automatic expect_word(bit wr, logic [21:0] a, logic [23:0] w, int nb, int tsel, string tag);
    for (int i = 0; i < nb; i++) begin
      acc_t e;
      e.wr  = wr;
      e.a   = a + 22'(i);
      e.d   = wr ? w[i*8 +: 8] : mem[e.a[11:0]];
      e.w   = width_of(tsel);
      e.tag = tag;
      exp_q.push_back(e);
    end
  endtask

  function automatic logic [23:0] model_word(logic [21:0] a, int nb);
    logic [23:0] r = '0;
    for (int i = 0; i < nb; i++) begin
      logic [21:0] ai = a + 22'(i);
      r[i*8 +: 8] = mem[ai[11:0]];
    end
    return r;
  endfunction

  // Monitor side: watches strobes, pops and compares.
  logic        prev_low = 1'b0, cur_wr = 1'b0, sl;
  logic [21:0] prev_addr = '0, cur_a = '0;
  logic [7:0]  cur_d = '0;
  int          low_n = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      sl = !sram_we_n || !sram_oe_n;
      if (sl) begin
        if (!prev_low) begin
          chk("R4 address setup before strobe", 32'(sram_addr), 32'(prev_addr));
          low_n = 0;
        end
        low_n++;
        cur_wr = !sram_we_n;
        cur_a  = sram_addr;
        cur_d  = sram_dq_o;
        chk("R11 bus drive matches access kind", 32'(sram_dq_oe), 32'(cur_wr));
      end else if (prev_low) begin
        chk("R4 address hold after strobe", 32'(sram_addr), 32'(cur_a));
        if (exp_q.size() == 0) begin
          n_tests++;
          n_fail++;
          $display("FAIL R10 unexpected access: actual addr %h expected none", cur_a);
        end else begin
          acc_t e;
          e = exp_q.pop_front();
          chk({e.tag, " kind"}, 32'(cur_wr), 32'(e.wr));
          chk({e.tag, " address"}, 32'(cur_a), 32'(e.a));
          chk({"R4 strobe width ", e.tag}, 32'(low_n), 32'(e.w));
          if (cur_wr) begin
            chk({e.tag, " write byte"}, 32'(cur_d), 32'(e.d));
            mem[cur_a[11:0]] = cur_d;
          end
        end
      end
      prev_low  = sl;
      prev_addr = sram_addr;
    end
  end

  task automatic reg_write(logic [2:0] a, logic [23:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [23:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(string tag);
    logic [23:0] s;
    for (int i = 0; i < 300; i++) begin
      reg_read(A_CTRL, s);
      if (!s[8]) return;
    end
    chk({tag, " busy timeout"}, 32'(1), 32'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [23:0] r;
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 write strobe idle", 32'(sram_we_n), 32'(1));
    chk("R1 read strobe idle", 32'(sram_oe_n), 32'(1));
    chk("R1 bus released", 32'(sram_dq_oe), 32'(0));
    chk("R1 irq low", 32'(irq), 32'(0));
    rst_n = 1'b1;
    reg_read(A_CTRL, r);
    chk("R1 status after reset", 32'(r[10:8]), 32'(0));

    // R2: 24-bit write, timing 0, offset 0, irq enabled.
    reg_write(A_CTRL, 24'h52);
    reg_write(A_BASE, 24'h000100);
    reg_write(A_OFS0, 24'h10);
    reg_write(A_OFS1, 24'h40);
    expect_word(1, 22'h110, 24'hA1B2C3, 3, 0, "R2 24-bit write");
    reg_write(A_WDAT, 24'hA1B2C3);
    wait_idle("R2");
    reg_read(A_CTRL, r);
    chk("R8 done set with config kept", 32'(r), 32'h252);
    chk("R9 irq with enable", 32'(irq), 32'(1));
    reg_read(A_OFS0, r);
    chk("R7 offset advanced by 3", 32'(r), 32'h13);

    // R3 16-bit write with timing 1.
    reg_write(A_CTRL, 24'h55);
    expect_word(1, 22'h113, 24'h005566, 2, 1, "R3 16-bit write");
    reg_write(A_WDAT, 24'h005566);
    wait_idle("R3");
    reg_read(A_OFS0, r);
    chk("R7 offset advanced by 2", 32'(r), 32'h15);

    // 8-bit write, timing 3, offset register 3 selected.
    reg_write(A_CTRL, 24'h7C);
    expect_word(1, 22'h140, 24'h77, 1, 3, "R2 8-bit write via offset 1");
    reg_write(A_WDAT, 24'h000077);
    wait_idle("R2b");
    reg_read(A_OFS1, r);
    chk("R7 offset 1 advanced by 1", 32'(r), 32'h41);

    // R5: read started by offset write, timing 2, irq disabled.
    reg_write(A_CTRL, 24'h0A);
    expect_word(0, 22'h110, 24'h0, 3, 2, "R5 offset-started read");
    reg_write(A_OFS0, 24'h10);
    wait_idle("R5");
    reg_read(A_RDAT, r);
    chk("R5 read word", 32'(r), 32'hA1B2C3);
    chk("R9 irq masked", 32'(irq), 32'(0));
    reg_read(A_CTRL, r);
    chk("R5 data read starts nothing", 32'(r[8]), 32'(0));
    reg_read(A_OFS0, r);
    chk("R7 offset after read", 32'(r), 32'h13);

    // R3: 16-bit read is zero-extended.
    reg_write(A_CTRL, 24'h01);
    expect_word(0, 22'h113, 24'h0, 2, 0, "R3 16-bit read");
    reg_write(A_OFS1, 24'h13);
    wait_idle("R3b");
    reg_read(A_RDAT, r);
    chk("R3 zero-extended word", 32'(r), 32'h005566);

    // R6: fetch mode, 8-bit words through offset register 3.
    reg_write(A_CTRL, 24'h30);
    reg_write(A_OFS1, 24'h40);
    reg_read(A_CTRL, r);
    chk("R6 offset write starts nothing", 32'(r[8]), 32'(0));
    expect_word(0, 22'h140, 24'h0, 1, 0, "R6 fetch read 1");
    reg_read(A_RDAT, r);
    chk("R6 returns previous word", 32'(r), 32'h005566);
    wait_idle("R6");
    expect_word(0, 22'h141, 24'h0, 1, 0, "R6 fetch read 2");
    reg_read(A_RDAT, r);
    chk("R6 returns fetched byte", 32'(r), 32'h000077);
    wait_idle("R6b");
    reg_write(A_CTRL, 24'h00);
    reg_read(A_RDAT, r);
    chk("R6 second fetched byte", 32'(r), 32'(model_word(22'h141, 1)));

    // R10: overrun during a long write.
    reg_write(A_CTRL, 24'h0E);
    expect_word(1, 22'h113, 24'h112233, 3, 3, "R10 running write");
    reg_write(A_WDAT, 24'h112233);
    reg_read(A_CTRL, r);
    chk("R8 busy set, done cleared on start", 32'(r[9:8]), 32'h1);
    reg_write(A_WDAT, 24'h999999);
    reg_write(A_OFS0, 24'h0);
    wait_idle("R10");
    reg_read(A_CTRL, r);
    chk("R10 overrun set", 32'(r[10]), 32'(1));
    reg_read(A_OFS0, r);
    chk("R10 offset write ignored while busy", 32'(r), 32'h16);
    reg_write(A_CTRL, 24'h40E);
    reg_read(A_CTRL, r);
    chk("R10 overrun cleared, done kept", 32'(r[10:9]), 32'h1);
    reg_write(A_CTRL, 24'h20E);
    reg_read(A_CTRL, r);
    chk("R8 done cleared by write-one", 32'(r[9]), 32'(0));

    // R2/R7 wrap at the top of the address space.
    reg_write(A_CTRL, 24'h12);
    reg_write(A_BASE, 24'h3FFFFE);
    reg_write(A_OFS0, 24'h0);
    expect_word(1, 22'h3FFFFE, 24'hCAFE01, 3, 0, "R2 address wrap");
    reg_write(A_WDAT, 24'hCAFE01);
    wait_idle("R2c");
    reg_read(A_OFS0, r);
    chk("R7 offset after wrap word", 32'(r), 32'h3);
    reg_write(A_CTRL, 24'h11);
    reg_write(A_BASE, 24'h0);
    reg_write(A_OFS0, 24'h3FFFFF);
    expect_word(1, 22'h3FFFFF, 24'h00BEEF, 2, 0, "R7 offset wrap write");
    reg_write(A_WDAT, 24'h00BEEF);
    wait_idle("R7");
    reg_read(A_OFS0, r);
    chk("R7 offset wraps", 32'(r), 32'h1);

    repeat (5) @(negedge clk);
    chk("R10 all expected accesses seen", 32'(exp_q.size()), 32'(0));
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule